// File: doc/BRIEF.md
# Byte-to-Word ATA Data Bridge

This block lets a host with a byte-wide I/O bus talk to an ATA-style device with a 16-bit data bus. The host uses read and write strobes that are one byte wide. A small register window selects the access type.

On a word read, the host gets the low byte of the device word straight away. The high byte is held in a read latch, and the host fetches it later through the high-byte offset. On a word write, the host first stores the high byte through that same offset. A low-byte write to the data offset then drives the complete word onto the device bus. All other offsets pass through as plain 8-bit device register accesses.

The model is synchronous, and every timing margin is a whole number of clock cycles. The device read strobe is stretched past the end of the host read strobe, so the high byte is always captured while the device still drives valid data. The device output enable is held past the end of the device write strobe, so write data stays valid after the write ends.

Top module: `ata_byte_bridge`

## Requirements
- R1: A host read at offset 0 (the data offset) starts a device read at device register 0. While the device data is valid, `host_rdata` shows bits 7:0 of `dev_din`.
- R2: When a host read at offset 0 ends, bits 15:8 of `dev_din` are captured into the high-byte read latch. This happens on the first clock edge at which `host_rd` is sampled low. A later host read at offset 8 returns that byte.
- R3: After the capture edge, `dev_rd` stays high for exactly READ_DLY more clock edges (READ_DLY >= 1). It falls on the READ_DLY-th edge after capture, so capture always comes before the device read ends.
- R4: A host read at offset 8 raises no device strobe. It returns the most recent captured value, and repeated reads return the same value.
- R5: A host write at offset 8 stores `host_wdata` in the high-byte write latch and raises no device strobe.
- R6: A host write at offset 0 asserts `dev_wr` one edge after `host_wr` is sampled high, and drops it one edge after `host_wr` is sampled low. During the write, `dev_dout` = {write latch, `host_wdata`} and `dev_oe` = 2'b11 (bit 1 enables bits 15:8, bit 0 enables bits 7:0). `dev_rd` and a nonzero `dev_oe` are never both asserted.
- R7: After `dev_wr` falls, `dev_oe` stays at its value for exactly WR_HOLD clock edges (WR_HOLD >= 1), and `dev_dout` does not change in that window.
- R8: Every offset other than 0 and 8 is an 8-bit passthrough to device register `host_addr[2:0]`.
  - A write drives bits 7:0 only, with `dev_oe` = 2'b01.
  - A read returns bits 7:0 and leaves the high-byte read latch unchanged.
- R9: Reset clears the read latch and the write latch to 0x00 and deasserts `dev_rd`, `dev_wr` and `dev_oe`.
- R10: While `dev_rd` or `dev_wr` is high, including the read and write tails, `dev_addr` holds the device register of the access that started them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 4 | Host register offset |
| host_rd | input | 1 | Host read strobe, active high |
| host_wr | input | 1 | Host write strobe, active high |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| dev_addr | output | 3 | Device register select |
| dev_rd | output | 1 | Device read strobe (stretched) |
| dev_wr | output | 1 | Device write strobe |
| dev_din | input | 16 | Data from the device |
| dev_dout | output | 16 | Data to the device |
| dev_oe | output | 2 | Per-byte-lane output enable |

## Verification
The assertions take three things for granted about the host:
- `host_addr` is stable for the whole of a strobe.
- `host_rd` and `host_wr` are never high together.
- Each strobe lasts at least two cycles, and consecutive strobes are separated by more than READ_DLY and WR_HOLD idle cycles, so no tail overlaps the next access.

Without these, the no-contention and capture checks could fire on a legal design. The stimulus always holds a strobe for three cycles and then idles for READ_DLY + WR_HOLD + 3 cycles before the next access.

The device model drives junk data from one cycle after `dev_rd` falls. A high byte captured late would therefore show up as a mismatch.

// File: rtl/ata_br_pkg.sv
package ata_br_pkg;

  typedef enum logic [1:0] {
    ACC_WORD = 2'd0,
    ACC_HIGH = 2'd1,
    ACC_BYTE = 2'd2
  } acc_kind_e;

  // Decide which kind of access a host offset selects.
  function automatic acc_kind_e classify(input int unsigned ofs,
                                         input int unsigned word_ofs,
                                         input int unsigned high_ofs);
    if (ofs == word_ofs) return ACC_WORD;
    if (ofs == high_ofs) return ACC_HIGH;
    return ACC_BYTE;
  endfunction

  // Byte-lane enable pattern for a device write: {upper lane, lower lane}.
  function automatic logic [1:0] lane_mask(input acc_kind_e k);
    return (k == ACC_WORD) ? 2'b11 : 2'b01;
  endfunction

  // Width of a down-counter that must hold the value t.
  function automatic int tail_width(input int t);
    return (t < 1) ? 1 : $clog2(t + 1);
  endfunction

endpackage

// File: rtl/strobe_stretch.sv
module strobe_stretch #(
  parameter int TAIL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  output logic strb,
  output logic ext
);
  import ata_br_pkg::*;

  localparam int CW = tail_width(TAIL);
  localparam logic [CW-1:0] TAIL_V = CW'(TAIL);

  logic [CW-1:0] tail_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strb     <= 1'b0;
      ext      <= 1'b0;
      tail_cnt <= '0;
    end else begin
      strb <= act;
      if (act) begin
        tail_cnt <= TAIL_V;
        ext      <= 1'b1;
      end else if (tail_cnt != '0) begin
        tail_cnt <= tail_cnt - CW'(1);
        ext      <= 1'b1;
      end else begin
        ext <= 1'b0;
      end
    end
  end

  // R3 R7: the stretched strobe never ends while the raw one is still high
  ext_covers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext) |-> !strb);

endmodule

// File: rtl/bridge_rd_path.sv
module bridge_rd_path #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_act,
  input  logic          rd_strb,
  input  logic          is_word,
  input  logic          sel_high,
  input  logic [2*BW-1:0] dev_din,
  output logic [BW-1:0] host_rdata,
  output logic          cap_evt
);
  logic          word_q;
  logic [BW-1:0] hi_rd_latch;

  // Remember whether the running read is a word read.
  always_ff @(posedge clk) begin
    if (!rst_n)      word_q <= 1'b0;
    else if (rd_act) word_q <= is_word;
  end

  // The capture fires on the edge at which the host strobe is first seen low.
  assign cap_evt = rd_strb && word_q && !rd_act;

  always_ff @(posedge clk) begin
    if (!rst_n)       hi_rd_latch <= '0;
    else if (cap_evt) hi_rd_latch <= dev_din[2*BW-1:BW];
  end

  assign host_rdata = sel_high ? hi_rd_latch : dev_din[BW-1:0];

  // R4: the latch only changes on a capture
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cap_evt) |-> $stable(hi_rd_latch));

endmodule

// File: rtl/bridge_wr_path.sv
module bridge_wr_path #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hi_wr_evt,
  input  logic            wr_act,
  input  ata_br_pkg::acc_kind_e kind,
  input  logic [BW-1:0]   host_wdata,
  input  logic            wr_ext,
  output logic [2*BW-1:0] dev_dout,
  output logic [1:0]      dev_oe
);
  import ata_br_pkg::*;

  logic [BW-1:0] hi_wr_latch;
  logic [1:0]    lanes_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         hi_wr_latch <= '0;
    else if (hi_wr_evt) hi_wr_latch <= host_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_dout <= '0;
      lanes_q  <= 2'b00;
    end else if (wr_act) begin
      dev_dout <= (kind == ACC_WORD) ? {hi_wr_latch, host_wdata}
                                     : {{BW{1'b0}}, host_wdata};
      lanes_q  <= lane_mask(kind);
    end
  end

  assign dev_oe = wr_ext ? lanes_q : 2'b00;

  // R5: the write latch changes only after a high-byte host write
  wlatch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hi_wr_evt) |-> $stable(hi_wr_latch));

endmodule

// File: rtl/ata_byte_bridge.sv
module ata_byte_bridge #(
  parameter int BW       = 8,
  parameter int HOST_AW  = 4,
  parameter int DEV_AW   = 3,
  parameter int WORD_OFS = 0,
  parameter int HI_OFS   = 8,
  parameter int READ_DLY = 2,
  parameter int WR_HOLD  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [BW-1:0]     host_wdata,
  output logic [BW-1:0]     host_rdata,
  output logic [DEV_AW-1:0] dev_addr,
  output logic              dev_rd,
  output logic              dev_wr,
  input  logic [2*BW-1:0]   dev_din,
  output logic [2*BW-1:0]   dev_dout,
  output logic [1:0]        dev_oe
);
  import ata_br_pkg::*;

  acc_kind_e kind;
  logic      rd_act, wr_act, hi_wr_evt, sel_high;
  logic      rd_strb, rd_ext, wr_strb, wr_ext, cap_evt;

  assign kind      = classify(int'(host_addr), WORD_OFS, HI_OFS);
  assign sel_high  = (kind == ACC_HIGH);
  assign rd_act    = host_rd && !sel_high;
  assign wr_act    = host_wr && !sel_high;
  assign hi_wr_evt = host_wr && sel_high;

  strobe_stretch #(.TAIL(READ_DLY)) u_rd_stretch (
    .clk(clk), .rst_n(rst_n), .act(rd_act), .strb(rd_strb), .ext(rd_ext));

  strobe_stretch #(.TAIL(WR_HOLD)) u_wr_stretch (
    .clk(clk), .rst_n(rst_n), .act(wr_act), .strb(wr_strb), .ext(wr_ext));

  assign dev_rd = rd_ext;
  assign dev_wr = wr_strb;

  always_ff @(posedge clk) begin
    if (!rst_n)                dev_addr <= '0;
    else if (rd_act || wr_act) dev_addr <= host_addr[DEV_AW-1:0];
  end

  bridge_rd_path #(.BW(BW)) u_rd_path (
    .clk(clk), .rst_n(rst_n), .rd_act(rd_act), .rd_strb(rd_strb),
    .is_word(kind == ACC_WORD), .sel_high(sel_high), .dev_din(dev_din),
    .host_rdata(host_rdata), .cap_evt(cap_evt));

  bridge_wr_path #(.BW(BW)) u_wr_path (
    .clk(clk), .rst_n(rst_n), .hi_wr_evt(hi_wr_evt), .wr_act(wr_act),
    .kind(kind), .host_wdata(host_wdata), .wr_ext(wr_ext),
    .dev_dout(dev_dout), .dev_oe(dev_oe));

  // R3
  capture_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> dev_rd);

  // R4
  hi_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_rd) |-> $past(host_rd && (int'(host_addr) != HI_OFS)));

  // R6
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_rd && (dev_oe != 2'b00)));

  // R7
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_wr) |-> (dev_oe != 2'b00));

  // R7
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dev_oe != 2'b00) && !dev_wr) |-> $stable(dev_dout));

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rd && $past(dev_rd) && !$past(host_rd)) |-> $stable(dev_addr));

endmodule

// File: tb/ata_byte_bridge_tb.sv
module ata_byte_bridge_tb;
  localparam int CLK_P    = 10;
  localparam int READ_DLY = 2;
  localparam int WR_HOLD  = 1;
  localparam int GAP      = READ_DLY + WR_HOLD + 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  host_addr = '0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic [2:0]  dev_addr;
  logic        dev_rd, dev_wr;
  logic [15:0] dev_din;
  logic [15:0] dev_dout;
  logic [1:0]  dev_oe;

  always #(CLK_P/2) clk = ~clk;

  ata_byte_bridge #(.READ_DLY(READ_DLY), .WR_HOLD(WR_HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .dev_addr(dev_addr), .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_din(dev_din),
    .dev_dout(dev_dout), .dev_oe(dev_oe));

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Device model: valid data one cycle after dev_rd is seen, junk otherwise.
  logic [15:0] dmem [8];
  logic        mvalid;
  logic [15:0] junk;
  always @(posedge clk) begin
    if (!rst_n) begin
      dev_din <= 16'h0; mvalid <= 1'b0; junk <= 16'hBAD1;
    end else begin
      junk <= junk + 16'h1357;
      if (dev_rd) begin dev_din <= dmem[dev_addr]; mvalid <= 1'b1; end
      else        begin dev_din <= junk;           mvalid <= 1'b0; end
    end
  end

  // Behavioural reference, advanced at every rising edge.
  int         rgap, wgap;
  logic [7:0] exp_hi, exp_hiw;
  logic [15:0] exp_word;
  logic [1:0] exp_lanes;
  logic [2:0] exp_addr;
  bit         prev_word_rd;
  always @(posedge clk) begin
    if (!rst_n) begin
      rgap = 1000; wgap = 1000; exp_hi = 0; exp_hiw = 0; exp_word = 0;
      exp_lanes = 0; exp_addr = 0; prev_word_rd = 0;
    end else begin
      if (prev_word_rd && !host_rd) exp_hi = dmem[0][15:8];
      prev_word_rd = host_rd && host_addr == 4'd0;
      if (host_rd && host_addr != 4'd8) begin rgap = 0; exp_addr = host_addr[2:0]; end
      else if (rgap < 1000) rgap++;
      if (host_wr && host_addr == 4'd8) begin
        exp_hiw = host_wdata;
        if (wgap < 1000) wgap++;
      end else if (host_wr) begin
        wgap = 0; exp_addr = host_addr[2:0];
        exp_word  = (host_addr == 4'd0) ? {exp_hiw, host_wdata} : {8'h00, host_wdata};
        exp_lanes = (host_addr == 4'd0) ? 2'b11 : 2'b01;
      end else if (wgap < 1000) wgap++;
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [1:0] eoe;
      eoe = (wgap <= WR_HOLD) ? exp_lanes : 2'b00;
      check("R3", "dev_rd", dev_rd, rgap <= READ_DLY);
      check("R6", "dev_wr", dev_wr, wgap == 0);
      check((wgap > 0) ? "R7" : "R6", "dev_oe", dev_oe, eoe);
      if (eoe == 2'b11)
        check((wgap > 0) ? "R7" : "R6", "dev_dout", dev_dout, exp_word);
      else if (eoe == 2'b01)
        check("R8", "dev_dout lo", dev_dout[7:0], exp_word[7:0]);
      if (dev_rd || dev_wr) check("R10", "dev_addr", dev_addr, exp_addr);
      if (host_rd && host_addr == 4'd8) check("R4", "host_rdata hi", host_rdata, exp_hi);
      else if (host_rd && mvalid) check("R1", "host_rdata lo", host_rdata, dmem[exp_addr][7:0]);
    end
  end

  task automatic host_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd = 1'b1;
    repeat (3) @(negedge clk);
    d = host_rdata;
    host_rd = 1'b0;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic host_write(input logic [3:0] a, input logic [7:0] v);
    @(negedge clk); host_addr = a; host_wdata = v; host_wr = 1'b1;
    repeat (3) @(negedge clk);
    host_wr = 1'b0;
    repeat (GAP) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    bit saw_wr;
    for (int i = 0; i < 8; i++) dmem[i] = 16'h1111 * (i + 1);
    repeat (2) @(negedge clk);
    // r9_ reset state
    check("R9", "dev_rd in reset", dev_rd, 0);
    check("R9", "dev_wr in reset", dev_wr, 0);
    check("R9", "dev_oe in reset", dev_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    host_read(4'd8, d);
    check("R9", "hi read latch after reset", d, 8'h00);

    // R9 write latch cleared; R6 word write
    fork
      host_write(4'd0, 8'h5A);
      begin
        saw_wr = 0;
        repeat (4) begin @(negedge clk); if (dev_wr) begin
          saw_wr = 1; check("R9", "word with cleared hi", dev_dout, 16'h005A); end end
      end
    join
    check("R6", "dev_wr seen", saw_wr, 1);

    // R5 high-byte write raises no strobe
    fork
      host_write(4'd8, 8'hC3);
      begin
        saw_wr = 0;
        repeat (4) begin @(negedge clk); if (dev_wr || dev_rd) saw_wr = 1; end
      end
    join
    check("R5", "no device strobe on hi write", saw_wr, 0);

    fork
      host_write(4'd0, 8'h7E);
      begin
        saw_wr = 0;
        repeat (6) begin @(negedge clk);
          if (dev_wr) saw_wr = 1;
          else if (saw_wr && dev_oe != 0)
            check("R7", "hold data", dev_dout, 16'hC37E);
        end
      end
    join
    check("R6", "word write seen", saw_wr, 1);

    // R1 R2 word read then high-byte fetch
    dmem[0] = 16'hA55A;
    host_read(4'd0, d);
    check("R1", "low byte", d, 8'h5A);
    host_read(4'd8, d);
    check("R2", "high byte", d, 8'hA5);
    host_read(4'd8, d);
    check("R4", "repeat high byte", d, 8'hA5);

    // R8 passthrough read leaves latch alone
    dmem[3] = 16'h1234;
    host_read(4'd3, d);
    check("R8", "byte read", d, 8'h34);
    host_read(4'd8, d);
    check("R8", "latch unchanged", d, 8'hA5);

    // R8 passthrough write via offset 11 -> device reg 3
    fork
      host_write(4'd11, 8'h99);
      begin
        saw_wr = 0;
        repeat (4) begin @(negedge clk); if (dev_wr) begin saw_wr = 1;
          check("R8", "byte lanes", dev_oe, 2'b01);
          check("R8", "byte addr", dev_addr, 3'd3); end end
      end
    join
    check("R8", "byte write seen", saw_wr, 1);

    // R2 several word patterns
    for (int k = 0; k < 6; k++) begin
      logic [15:0] w;
      w = 16'h0FF0 ^ (16'h3C5A * (k + 1));
      dmem[0] = w;
      host_read(4'd0, d);
      check("R1", "low byte pattern", d, w[7:0]);
      host_read(4'd8, d);
      check("R2", "high byte pattern", d, w[15:8]);
    end

    repeat (4) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule